// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block gathers a set of internal status lines (sixteen by default) into one shared interrupt request. Each status line has its own enable bit in a small bank of byte-wide mask registers. An enabled line that goes from low to high marks its source as pending. The block asks for the interrupt line to be pulled low for as long as any source is pending. One source, chosen by a parameter, is always enabled, whatever its mask bit holds.

Software reaches the block through a simple byte register port, with a read strobe, a write strobe, an address and the data. The serial bus that carries these accesses lives outside the block. Status registers return the live level of the status inputs, not a copy frozen when the interrupt fired, so a later event can replace an earlier one. Reading a status register releases the pending flags of the eight sources that register shows. The interrupt pin itself is open-drain and active low, so the block drives only the enable for the pull-down.

Top module: `irq_status_ctrl`

## Requirements
- R1: `irq_pull_en` is 1 in exactly the cycles that follow an edge which left at least one source pending, and it returns to 0 one cycle after the last pending flag is cleared.
- R2: A rising edge on `status_in[i]` (low in the previous cycle, high in this one) sets pending flag i at the next clock edge if source i is enabled in that cycle. An edge on a disabled source is lost.
- R3: Source `ALWAYS_ON_IDX` (default 15) is enabled whatever its mask bit holds. Its mask bit always reads back as 1, and writing to that bit has no effect.
- R4: After reset, every mask bit reads 0 except the always-on bit, no flag is pending, `irq_pull_en` is 0 and `rdata` is 0.
- R5: The mask registers sit at address 0x2D (sources 7..0, bit n is source n) and 0x2E (sources 15..8, bit n is source 8+n). A write stores `wdata` and a later read returns it.
- R6: The status registers sit at 0x1E (sources 7..0) and 0x1F (sources 15..8), using the same bit order as the masks. A read returns the live `status_in` byte of the read cycle. `rdata` is updated on the clock edge that ends a cycle with `rd_en` high, and it holds its value in every other cycle.
- R7: A read of a status register clears the pending flags of the eight sources in that register and leaves every other pending flag as it was.
- R8: A rising edge on an enabled source in the same cycle as a read of its status register leaves that source pending.
- R9: A mask write that puts 0 into the bit of a non-always-on source clears that source's pending flag. This includes an edge arriving in the same cycle as the write.
- R10: Writes to the status registers or to unmapped addresses change neither the masks nor the pending flags. A read of an unmapped address returns 0.
- R11: A status input that stays high does not set its pending flag again once the flag has been cleared. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| status_in | input | NUM_SRC | Internal status lines, synchronous to clk |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| irq_pull_en | output | 1 | Enable for the open-drain pull-down of the active-low interrupt pin |

## Verification
Every pending flag shows up at `irq_pull_en` exactly one cycle after the edge, read or mask write that should change it. A flag that is stuck, set when it should not be, or left uncleared therefore shows as an interrupt level that is wrong in the very next cycle. A wrong mask bit shows twice: in the read-back one cycle after the read, and in whether a later edge raises the interrupt. The bench follows both outputs against its own model on every cycle, so any difference is reported in the cycle where it first appears.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned byte_banks(input int unsigned n_src);
    return (n_src + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANK  = 2,
  parameter int unsigned MASK_BASE = 'h2D,
  parameter int unsigned STAT_BASE = 'h1E
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_en,
  input  logic                wr_en,
  output logic [NUM_BANK-1:0] mask_wr_sel,
  output logic [NUM_BANK-1:0] mask_rd_sel,
  output logic [NUM_BANK-1:0] stat_rd_sel
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(MASK_BASE + b);
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(STAT_BASE + b);
    logic hit_mask;
    logic hit_stat;
    always_comb begin
      hit_mask       = (addr == MADDR);
      hit_stat       = (addr == SADDR);
      mask_wr_sel[b] = wr_en & hit_mask;
      mask_rd_sel[b] = rd_en & hit_mask;
      stat_rd_sel[b] = rd_en & hit_stat;
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC       = 16,
  parameter int unsigned NUM_BANK      = 2,
  parameter int unsigned ALWAYS_ON_IDX = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANK-1:0]        wr_sel,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [NUM_BANK*BYTE_W-1:0] mask_eff,
  output logic [NUM_SRC-1:0]         dis_clr
);
  localparam int unsigned PAD_W = NUM_BANK * BYTE_W;
  localparam logic [PAD_W-1:0] VALID_VEC = {PAD_W{1'b1}} >> (PAD_W - NUM_SRC);
  localparam logic [PAD_W-1:0] AO_VEC    = PAD_W'(1) << ALWAYS_ON_IDX;
  localparam logic [PAD_W-1:0] STORE_VEC = VALID_VEC & ~AO_VEC;

  logic [PAD_W-1:0] mask_q;
  logic [PAD_W-1:0] mask_d;
  logic [PAD_W-1:0] clr_pad;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [BYTE_W-1:0] keep;
    always_comb begin
      keep = STORE_VEC[b*BYTE_W +: BYTE_W];
      if (wr_sel[b]) begin
        mask_d[b*BYTE_W +: BYTE_W]  = wdata & keep;
        clr_pad[b*BYTE_W +: BYTE_W] = ~wdata & keep;
      end else begin
        mask_d[b*BYTE_W +: BYTE_W]  = mask_q[b*BYTE_W +: BYTE_W];
        clr_pad[b*BYTE_W +: BYTE_W] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_eff = mask_q | (AO_VEC & VALID_VEC);
  assign dis_clr  = clr_pad[NUM_SRC-1:0];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] level_in,
  output logic [NUM_SRC-1:0] rise
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_in;
  end

  assign rise = level_in & ~prev_q;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] clr_rd,
  input  logic [NUM_SRC-1:0] clr_dis,
  output logic [NUM_SRC-1:0] pend,
  output logic               any_pend
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic               any_q;

  always_comb begin
    pend_d = ((pend_q & ~clr_rd) | (rise & en)) & ~clr_dis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      any_q  <= |pend_d;
    end
  end

  assign pend     = pend_q;
  assign any_pend = any_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && en[i] && !clr_dis[i]) |=> pend_q[i]);
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd[i] && !(rise[i] && en[i])) |=> !pend_q[i]);
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_dis[i] |=> !pend_q[i]);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !rise[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC       = 16,
  parameter int unsigned ALWAYS_ON_IDX = 15,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned MASK_BASE     = 'h2D,
  parameter int unsigned STAT_BASE     = 'h1E,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_in,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  output logic               irq_pull_en
);
  localparam int unsigned NUM_BANK = byte_banks(NUM_SRC);
  localparam int unsigned PAD_W    = NUM_BANK * BYTE_W;
  localparam int unsigned AO_BANK  = ALWAYS_ON_IDX / BYTE_W;
  localparam int unsigned AO_BIT   = ALWAYS_ON_IDX % BYTE_W;
  localparam logic [ADDR_W-1:0] AO_ADDR = ADDR_W'(MASK_BASE + AO_BANK);

  logic                rst_sync_n;
  logic [NUM_BANK-1:0] mask_wr_sel;
  logic [NUM_BANK-1:0] mask_rd_sel;
  logic [NUM_BANK-1:0] stat_rd_sel;
  logic [PAD_W-1:0]    mask_eff;
  logic [PAD_W-1:0]    status_pad;
  logic [NUM_SRC-1:0]  dis_clr;
  logic [NUM_SRC-1:0]  rise;
  logic [NUM_SRC-1:0]  clr_rd;
  logic [NUM_SRC-1:0]  pend;
  logic                any_pend;
  logic [BYTE_W-1:0]   rd_mux;
  logic [BYTE_W-1:0]   rdata_q;
  logic [BYTE_W-1:0]   rdata_d;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANK  (NUM_BANK),
    .MASK_BASE (MASK_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_decode (
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .mask_wr_sel (mask_wr_sel),
    .mask_rd_sel (mask_rd_sel),
    .stat_rd_sel (stat_rd_sel)
  );

  irq_mask_regs #(
    .NUM_SRC       (NUM_SRC),
    .NUM_BANK      (NUM_BANK),
    .ALWAYS_ON_IDX (ALWAYS_ON_IDX)
  ) u_masks (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_sel   (mask_wr_sel),
    .wdata    (wdata),
    .mask_eff (mask_eff),
    .dis_clr  (dis_clr)
  );

  irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edges (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .level_in (status_in),
    .rise     (rise)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_rd[i] = stat_rd_sel[i / BYTE_W];
  end

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rise     (rise),
    .en       (mask_eff[NUM_SRC-1:0]),
    .clr_rd   (clr_rd),
    .clr_dis  (dis_clr),
    .pend     (pend),
    .any_pend (any_pend)
  );

  assign status_pad = PAD_W'(status_in);

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(NUM_BANK); b++) begin
      if (mask_rd_sel[b]) rd_mux = rd_mux | mask_eff[b*BYTE_W +: BYTE_W];
      if (stat_rd_sel[b]) rd_mux = rd_mux | status_pad[b*BYTE_W +: BYTE_W];
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata       = rdata_q;
  assign irq_pull_en = any_pend;

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rdata));
  p_always_on_reads_one_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && addr == AO_ADDR) |=> rdata[AO_BIT]);
  p_irq_after_pend_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|pend) |-> irq_pull_en);
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam int unsigned NSRC = 16;
  localparam int unsigned AO   = 15;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] status_in;
  logic            rd_en;
  logic            wr_en;
  logic [7:0]      addr;
  logic [7:0]      wdata;
  logic [7:0]      rdata;
  logic            irq_pull_en;

  int checks;
  int errors;
  bit done;

  irq_status_ctrl u_irq_status_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_in   (status_in),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq_pull_en (irq_pull_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model
  logic [NSRC-1:0] m_mask, m_pend, m_prev;
  logic [7:0]      m_rdata;

  function automatic logic [NSRC-1:0] eff_mask(input logic [NSRC-1:0] m);
    return m | (NSRC'(1) << AO);
  endfunction

  function automatic logic [7:0] read_value(input logic [7:0] a,
                                            input logic [NSRC-1:0] m,
                                            input logic [NSRC-1:0] st);
    logic [NSRC-1:0] e;
    e = eff_mask(m);
    case (a)
      8'h2D:   return e[7:0];
      8'h2E:   return e[15:8];
      8'h1E:   return st[7:0];
      8'h1F:   return st[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] next_pend(input logic [NSRC-1:0] p,
      input logic [NSRC-1:0] m, input logic [NSRC-1:0] prev,
      input logic [NSRC-1:0] st, input logic r, input logic w,
      input logic [7:0] a, input logic [7:0] d);
    logic [NSRC-1:0] clr, dis, rs;
    rs  = st & ~prev;
    clr = '0;
    dis = '0;
    if (r && a == 8'h1E) clr[7:0]  = 8'hFF;
    if (r && a == 8'h1F) clr[15:8] = 8'hFF;
    if (w && a == 8'h2D) dis[7:0]  = ~d;
    if (w && a == 8'h2E) dis[15:8] = ~d;
    dis[AO] = 1'b0;
    return ((p & ~clr) | (rs & eff_mask(m))) & ~dis;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0; m_pend <= '0; m_prev <= '0; m_rdata <= '0;
    end else begin
      m_pend <= next_pend(m_pend, m_mask, m_prev, status_in, rd_en, wr_en, addr, wdata);
      m_prev <= status_in;
      if (rd_en) m_rdata <= read_value(addr, m_mask, status_in);
      if (wr_en && addr == 8'h2D) m_mask[7:0]  <= wdata;
      if (wr_en && addr == 8'h2E) m_mask[15:8] <= {1'b0, wdata[6:0]};
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " irq (R1)"}, {7'd0, irq_pull_en}, {7'd0, |m_pend});
    check({tag, " rdata (R6)"}, rdata, m_rdata);
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    step(tag);
    idle();
    check(tag, rdata, exp);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; addr = a; wdata = d;
    step(tag);
    idle();
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    check(tag, {7'd0, irq_pull_en}, {7'd0, exp});
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    checks = 0; errors = 0;
    status_in = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step("reset settle");

    // R4 reset state
    expect_irq(1'b0, "R4 irq after reset");
    check("R4 rdata after reset", rdata, 8'h00);
    do_read(8'h2D, 8'h00, "R4 mask low reset");
    do_read(8'h2E, 8'h80, "R4 R3 mask high reset");

    // R3 always-on source fires with all masks clear
    status_in[15] = 1'b1;
    step("R3 edge");
    expect_irq(1'b1, "R3 always-on fires");
    do_write(8'h2E, 8'h00, "R3 write zero");
    do_read(8'h2E, 8'h80, "R3 bit unchanged");
    expect_irq(1'b1, "R3 pending kept");
    do_read(8'h1F, 8'h80, "R6 live status high");
    expect_irq(1'b0, "R7 read clears");

    // R2 disabled edge lost, enabled edge pends
    status_in[3] = 1'b1;
    step("R2 masked edge");
    expect_irq(1'b0, "R2 masked edge lost");
    do_write(8'h2D, 8'h08, "R5 enable src3");
    do_read(8'h2D, 8'h08, "R5 readback");
    expect_irq(1'b0, "R2 no retro pend");
    status_in[3] = 1'b0; step("R2 low");
    status_in[3] = 1'b1; step("R2 rise");
    expect_irq(1'b1, "R2 enabled edge pends");

    // R7 other bank read does not clear
    do_read(8'h1F, 8'h80, "R7 other bank");
    expect_irq(1'b1, "R7 other bank keeps");
    do_read(8'h1E, 8'h08, "R6 live low bank");
    expect_irq(1'b0, "R7 own bank clears");

    // R11 steady high does not re-pend
    repeat (4) step("R11 hold");
    expect_irq(1'b0, "R11 no re-pend");

    // R8 edge during read stays pending
    status_in[3] = 1'b0; step("R8 low");
    status_in[3] = 1'b1;
    do_read(8'h1E, 8'h08, "R8 read with edge");
    expect_irq(1'b1, "R8 same-cycle edge kept");

    // R9 disable clears
    do_write(8'h2D, 8'h00, "R9 disable");
    expect_irq(1'b0, "R9 disable clears");
    do_write(8'h2D, 8'h08, "R9 reenable");
    status_in[3] = 1'b0; step("R9 low");
    status_in[3] = 1'b1;
    do_write(8'h2D, 8'h00, "R9 disable with edge");
    expect_irq(1'b0, "R9 same-cycle edge dropped");

    // R10 ignored writes, unmapped reads
    do_write(8'h2D, 8'h08, "R10 setup");
    status_in[3] = 1'b0; step("R10 low");
    status_in[3] = 1'b1; step("R10 rise");
    do_write(8'h1E, 8'h00, "R10 status write");
    do_write(8'h40, 8'hFF, "R10 unmapped write");
    expect_irq(1'b1, "R10 pending untouched");
    do_read(8'h2D, 8'h08, "R10 mask untouched");
    do_read(8'h40, 8'h00, "R10 unmapped read");
    do_read(8'h1E, 8'h08, "R10 status is live");

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned pick;
      for (int b = 0; b < int'(NSRC); b++)
        if ($urandom_range(0, 7) == 0) status_in[b] = ~status_in[b];
      rd_en = ($urandom_range(0, 3) == 0);
      wr_en = ($urandom_range(0, 5) == 0);
      pick  = $urandom_range(0, 4);
      case (pick)
        0: addr = 8'h2D;
        1: addr = 8'h2E;
        2: addr = 8'h1E;
        3: addr = 8'h1F;
        default: addr = 8'($urandom);
      endcase
      wdata = 8'($urandom);
      step("R2 R5 R7 R9 random");
    end
    idle();
    step("R6 final");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule